// File: doc/BRIEF.md
# Externally Clocked Up-Counter Timer

This block is a 16-bit up-counting timer. Its count enable comes either from the timer clock itself (internal mode) or from edges on one of two external input pins (external mode). In external mode a trigger selector picks one of three sources: every edge of pin 1, the conditioned active edge of pin 1, or the conditioned active edge of pin 2. Each pin is first brought into the timer clock domain by a two-stage synchronizer. It then passes a programmable glitch filter. A polarity choice decides whether the rising or the falling filtered edge is the active one.

The selected enable pulses drive a prescaler that lets through one pulse out of every divider+1. Each pulse that gets through advances the counter. The counter wraps from the period value to zero and sets a sticky overflow flag. A divider value written by software waits in a holding register. It becomes active only at the next overflow, so a period that is already running keeps its rate. Software configures the block through a simple write-only port.

Top module: `extclk_timer`

## Requirements
- R1: After reset the count output is 0 and the overflow flag is 0. Also at reset: period is 0xFFFF, divider is 0, the mode field is 0 (internal) and the enable bit is 0.
- R2: The control word sits at address 0: bit 0 enable, bits [3:1] mode, bits [6:4] trigger select. While enabled with a mode other than 3'b111, the prescaler receives one pulse per timer clock. With divider 0 the count then rises by one per clock.
- R3: The period sits at address 3. An increment taken while the count equals the period loads 0 and sets the overflow flag.
- R4: The overflow flag stays at 1 until a write to address 4 with data bit 0 equal to 0. When that clear falls in the same clock as an overflow, the flag ends at 1.
- R5: With the enable bit at 0, neither the count nor the prescaler's progress changes, in either mode. Counting resumes from where it stopped.
- R6: The divider sits at address 2. With divider D active, one count increment happens per D+1 prescaler pulses. A written divider value becomes active only at the next overflow.
- R7: In mode 3'b111 with trigger select 3'b101, each active edge of conditioned pin 1 gives one prescaler pulse. Active is rising when the polarity bit is 0.
- R8: Input settings sit at address 1: pin 1 filter [3:0], pin 1 polarity [4], pin 2 filter [11:8], pin 2 polarity [12]. With trigger select 3'b110 and pin 2 polarity 1, only falling edges of conditioned pin 2 give pulses, and pin 1 is ignored.
- R9: With trigger select 3'b100, both rising and falling edges of pin 1 give pulses, and pin 2 is ignored.
- R10: With filter 0, consider a pin change presented before a clock edge. The count does not show it after three clock edges, and does show it after the fourth.
- R11: With filter setting N, a pin level held for fewer than N+1 synchronized samples is ignored. An accepted edge reaches the count N clocks later than in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| ch1_in | input | 1 | External input pin 1 |
| ch2_in | input | 1 | External input pin 2 |
| count_o | output | 16 | Current counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The overflow event and the software clear of the flag can land in the same clock. The bench provokes this in internal mode with divider 0 and a short period, where the cycle of each wrap is known exactly. It times the clear write so that it is registered on the very edge where the count goes from the period back to 0. The flag is expected to read 1 afterwards. A clear placed a few cycles earlier is expected to read 0, which shows the clear path does work on its own.

// File: rtl/ectmr_pkg.sv
package ectmr_pkg;
   // operating modes
   localparam logic [2:0] MODE_INT = 3'b000;
   localparam logic [2:0] MODE_EXT = 3'b111;
   // trigger sources (decoded by the selector)
   localparam logic [2:0] TRG_P1_ANY  = 3'b100;
   localparam logic [2:0] TRG_P1_COND = 3'b101;
   localparam logic [2:0] TRG_P2_COND = 3'b110;
   // register addresses
   localparam int A_CTRL  = 0;
   localparam int A_INCFG = 1;
   localparam int A_DIV   = 2;
   localparam int A_PER   = 3;
   localparam int A_STAT  = 4;
   // bit spacing of per-pin fields in the input settings word
   localparam int CH_STRIDE = 8;
endpackage

// File: rtl/ectmr_in_cond.sv
module ectmr_in_cond #(
   parameter int FLT_W  = 4,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  logic [FLT_W-1:0] flt_set,
   input  logic             inv,
   output logic             any_edge,
   output logic             act_edge
);
   logic [SYNC_N-1:0] sync_q;
   logic [FLT_W-1:0]  run_q;
   logic              flt_q;
   logic              prev_q;
   logic              smp;
   logic              rise;
   logic              fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_N-2:0], pin};
   end

   assign smp = sync_q[SYNC_N-1];

   // filter: output follows the input once it differs for flt_set+1 samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         flt_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         prev_q <= flt_q;
         if (smp == flt_q) begin
            run_q <= '0;
         end else if (run_q >= flt_set) begin
            flt_q <= smp;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign rise     = flt_q & ~prev_q;
   assign fall     = ~flt_q & prev_q;
   assign any_edge = rise | fall;
   assign act_edge = inv ? fall : rise;
endmodule

// File: rtl/ectmr_prescale.sv
module ectmr_prescale #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [DIV_W-1:0] div_hold,
   input  logic             reload,
   output logic             cnt_en
);
   logic [DIV_W-1:0] act_q;
   logic [DIV_W-1:0] pcnt_q;

   assign cnt_en = tick && (pcnt_q >= act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= '0;
         pcnt_q <= '0;
      end else begin
         if (tick)   pcnt_q <= cnt_en ? '0 : pcnt_q + 1'b1;
         if (reload) act_q  <= div_hold;
      end
   end
endmodule

// File: rtl/ectmr_counter.sv
module ectmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic [CNT_W-1:0] period,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_evt,
   output logic             ovf_flag
);
   assign ovf_evt = cnt_en && (count == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         ovf_flag <= 1'b0;
      end else begin
         if (cnt_en)        count    <= ovf_evt ? '0 : count + 1'b1;
         if (ovf_evt)       ovf_flag <= 1'b1;
         else if (flag_clr) ovf_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/extclk_timer.sv
module extclk_timer
   import ectmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 16,
   parameter int FLT_W  = 4,
   parameter int SYNC_N = 2,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ch1_in,
   input  logic              ch2_in,
   output logic [CNT_W-1:0]  count_o,
   output logic              ovf_flag_o
);
   localparam int NCH = 2;

   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end
   if (DATA_W < CNT_W || DATA_W < DIV_W) begin : g_bad_data
      $error("DATA_W narrower than counter or divider");
   end
   if (DATA_W < CH_STRIDE + FLT_W + 1 || FLT_W > CH_STRIDE - 1) begin : g_bad_flt
      $error("filter field does not fit the input settings word");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end

   logic                      en_q;
   logic [2:0]                mode_q;
   logic [2:0]                trg_q;
   logic [DIV_W-1:0]          div_q;
   logic [CNT_W-1:0]          period_q;
   logic [NCH-1:0][FLT_W-1:0] flt_set_q;
   logic [NCH-1:0]            inv_q;
   logic [NCH-1:0]            pin_v;
   logic [NCH-1:0]            any_edge;
   logic [NCH-1:0]            act_edge;
   logic                      sel_edge;
   logic                      tick;
   logic                      cnt_en;
   logic                      ovf_evt;
   logic                      flag_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         mode_q    <= MODE_INT;
         trg_q     <= '0;
         div_q     <= '0;
         period_q  <= '1;
         flt_set_q <= '0;
         inv_q     <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_W'(A_CTRL): begin
               en_q   <= wr_data[0];
               mode_q <= wr_data[3:1];
               trg_q  <= wr_data[6:4];
            end
            ADDR_W'(A_INCFG): begin
               for (int c = 0; c < NCH; c++) begin
                  flt_set_q[c] <= wr_data[c*CH_STRIDE +: FLT_W];
                  inv_q[c]     <= wr_data[c*CH_STRIDE + FLT_W];
               end
            end
            ADDR_W'(A_DIV): div_q    <= wr_data[DIV_W-1:0];
            ADDR_W'(A_PER): period_q <= wr_data[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   assign flag_clr = wr_en && (wr_addr == ADDR_W'(A_STAT)) && !wr_data[0];

   assign pin_v = {ch2_in, ch1_in};

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ectmr_in_cond #(.FLT_W(FLT_W), .SYNC_N(SYNC_N)) u_cond (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (pin_v[c]),
         .flt_set (flt_set_q[c]),
         .inv     (inv_q[c]),
         .any_edge(any_edge[c]),
         .act_edge(act_edge[c])
      );
   end

   always_comb begin
      case (trg_q)
         TRG_P1_ANY:  sel_edge = any_edge[0];
         TRG_P1_COND: sel_edge = act_edge[0];
         TRG_P2_COND: sel_edge = act_edge[1];
         default:     sel_edge = 1'b0;
      endcase
   end

   assign tick = en_q && ((mode_q == MODE_EXT) ? sel_edge : 1'b1);

   ectmr_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .div_hold(div_q),
      .reload  (ovf_evt),
      .cnt_en  (cnt_en)
   );

   ectmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .period  (period_q),
      .flag_clr(flag_clr),
      .count   (count_o),
      .ovf_evt (ovf_evt),
      .ovf_flag(ovf_flag_o)
   );
endmodule

// File: rtl/ectmr_chk.sv
module ectmr_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_q,
   input logic             tick,
   input logic             cnt_en,
   input logic             flag_clr,
   input logic [CNT_W-1:0] period_q,
   input logic [CNT_W-1:0] count_o,
   input logic             ovf_flag_o
);
   // R2: a taken increment below the period adds one
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && count_o != period_q) |=> (count_o == $past(count_o) + 1'b1));

   // R3: increment at the period wraps to zero and raises the flag
   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && count_o == period_q) |=> (count_o == '0 && ovf_flag_o));

   // R4: flag holds without a clear
   assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag_o && !flag_clr) |=> ovf_flag_o);

   // R5: disabled timer keeps its count
   assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(count_o));

   // R6: prescaler never releases an increment without an input pulse
   assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |-> tick);
endmodule

bind extclk_timer ectmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_q      (en_q),
   .tick      (tick),
   .cnt_en    (cnt_en),
   .flag_clr  (flag_clr),
   .period_q  (period_q),
   .count_o   (count_o),
   .ovf_flag_o(ovf_flag_o)
);

// File: tb/sim_extclk_timer.sv
module sim_extclk_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        ch1_in = 1'b0;
   logic        ch2_in = 1'b0;
   logic [15:0] count_o;
   logic        ovf_flag_o;

   int unsigned cyc = 0;
   int          nchk = 0;
   int          nfail = 0;

   typedef struct {
      int unsigned cyc;
      logic [15:0] cnt;
      logic        flg;
      string       tag;
   } item_t;
   item_t sb[$];

   extclk_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ch1_in(ch1_in), .ch2_in(ch2_in), .count_o(count_o), .ovf_flag_o(ovf_flag_o)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare due items at the falling edge
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         item_t it;
         it = sb.pop_front();
         nchk++;
         if (it.cyc != cyc || count_o !== it.cnt || ovf_flag_o !== it.flg) begin
            nfail++;
            $display("FAIL %s: count=%0h flag=%0b expected count=%0h flag=%0b",
                     it.tag, count_o, ovf_flag_o, it.cnt, it.flg);
         end
      end
   end

   task automatic expect_at(input int unsigned d, input logic [15:0] c, input logic f,
                            input string tag);
      item_t it;
      it.cyc = cyc + d;
      it.cnt = c;
      it.flg = f;
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic look(input logic [15:0] c, input logic f, input string tag);
      expect_at(1, c, f, tag);
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int ch);
      if (ch == 1) ch1_in = 1'b1; else ch2_in = 1'b1;
      repeat (8) @(negedge clk);
      if (ch == 1) ch1_in = 1'b0; else ch2_in = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      look(16'd0, 1'b0, "R1 reset state");

      // internal mode, period 5, divider 0
      wr(3'd3, 16'd5);
      wr(3'd0, 16'h0001);
      expect_at(3,  16'd3, 1'b0, "R2 per-clock count");
      expect_at(6,  16'd0, 1'b1, "R3 wrap and flag");
      expect_at(7,  16'd1, 1'b1, "R4 flag sticky");
      expect_at(9,  16'd3, 1'b0, "R4 clear");
      expect_at(12, 16'd0, 1'b1, "R4 set beats clear");
      expect_at(13, 16'd1, 1'b1, "R5 last step before stop");
      expect_at(20, 16'd1, 1'b1, "R5 frozen");
      repeat (8) @(negedge clk);
      wr(3'd4, 16'd0);
      repeat (2) @(negedge clk);
      wr(3'd4, 16'd0);
      wr(3'd0, 16'h0000);
      repeat (8) @(negedge clk);

      // divider takes effect only at overflow
      wr(3'd4, 16'd0);
      wr(3'd3, 16'd3);
      wr(3'd2, 16'd1);
      wr(3'd0, 16'h0001);
      expect_at(2, 16'd3, 1'b0, "R6 old divider still active");
      expect_at(3, 16'd0, 1'b1, "R6 overflow loads divider");
      expect_at(4, 16'd0, 1'b1, "R6 new divider hold");
      expect_at(5, 16'd1, 1'b1, "R6 new divider step");
      expect_at(6, 16'd1, 1'b1, "R6 new divider hold");
      expect_at(7, 16'd2, 1'b1, "R6 new divider step");
      repeat (7) @(negedge clk);
      wr(3'd0, 16'h0000);

      // external, pin 1 conditioned rising edges; prescaler kept its progress
      wr(3'd4, 16'd0);
      wr(3'd2, 16'd0);
      wr(3'd1, 16'd0);
      wr(3'd0, 16'h005F);
      pulse(1);
      look(16'd3, 1'b0, "R7 R5 first edge completes frozen divide");
      pulse(1);
      pulse(1);
      look(16'd0, 1'b1, "R7 edge wrap");
      pulse(1);
      pulse(1);
      look(16'd2, 1'b1, "R7 one count per edge");
      wr(3'd3, 16'd100);

      // latency with filter 0
      ch1_in = 1'b1;
      expect_at(3, 16'd2, 1'b1, "R10 not yet");
      expect_at(4, 16'd3, 1'b1, "R10 arrives");
      repeat (8) @(negedge clk);
      ch1_in = 1'b0;
      repeat (8) @(negedge clk);

      // filter 2: glitch rejected, accepted edge delayed
      wr(3'd1, 16'd2);
      ch1_in = 1'b1;
      repeat (2) @(negedge clk);
      ch1_in = 1'b0;
      repeat (10) @(negedge clk);
      look(16'd3, 1'b1, "R11 short pulse ignored");
      ch1_in = 1'b1;
      expect_at(5, 16'd3, 1'b1, "R11 delayed not yet");
      expect_at(6, 16'd4, 1'b1, "R11 delayed arrives");
      repeat (10) @(negedge clk);
      ch1_in = 1'b0;
      repeat (10) @(negedge clk);

      // pin 2, inverted polarity
      wr(3'd1, 16'h1000);
      wr(3'd0, 16'h006F);
      ch2_in = 1'b1;
      repeat (10) @(negedge clk);
      look(16'd4, 1'b1, "R8 rising ignored");
      ch2_in = 1'b0;
      repeat (10) @(negedge clk);
      look(16'd5, 1'b1, "R8 falling counts");
      pulse(1);
      look(16'd5, 1'b1, "R8 pin 1 ignored");

      // pin 1, both edges
      wr(3'd0, 16'h004F);
      wr(3'd1, 16'd0);
      ch1_in = 1'b1;
      repeat (10) @(negedge clk);
      look(16'd6, 1'b1, "R9 rising counts");
      ch1_in = 1'b0;
      repeat (10) @(negedge clk);
      look(16'd7, 1'b1, "R9 falling counts");
      pulse(2);
      look(16'd7, 1'b1, "R9 pin 2 ignored");

      // disabled in external mode
      wr(3'd0, 16'h004E);
      pulse(1);
      look(16'd7, 1'b1, "R5 external frozen");

      repeat (4) @(negedge clk);
      if (sb.size() != 0) begin
         nchk++;
         nfail++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
      end
      summary();
      $finish;
   end
endmodule